// File: doc/BRIEF.md
# Registered Address Buffer with Parity

This block is a one-deep register stage for a memory command and address word. On each rising clock edge it captures 22 data bits together with two chip-select bits, two clock-enable bits and two termination-control bits. Every captured bit leaves the block on two identical output copies, A and B. The two copies let a module with many memory devices split the output load across two nets.

The data bits can be frozen. When the gate-enable strap is high and both active-low chip selects are high, no rank is addressed, so the 22 data outputs keep their previous values. The control bits pass through on every edge. Alongside the data path, a checker uses even parity over the captured data bits and the incoming parity bit. It reports a mismatch one clock later on an active-low error flag. A synchronous active-high reset clears every output to zero and drives the error flag high. Reset takes priority over gating.

Top module: `cmd_addr_regbuf`

## Requirements
- R1: During the cycle after a rising edge with `rst` high, all data, chip-select, clock-enable and termination outputs on both copies are 0, and `par_err_n` is 1.
- R2: When a rising edge captures (gate_en low, or cs_n_in not 2'b11), q_data_a and q_data_b show the d_in value from that edge.
- R3: Copy A and copy B of every output field are equal at all times.
- R4: With gate_en high and cs_n_in equal to 2'b11 at an edge, q_data_a and q_data_b keep their previous values.
- R5: With gate_en low, the data outputs load d_in on every edge, even when cs_n_in is 2'b11.
- R6: q_cs_n, q_cke and q_odt on both copies always show the cs_n_in, cke_in and odt_in values from the previous edge, gated or not.
- R7: Parity is even over d_in[21:0] and par_in. If the XOR of these 23 bits was 1 at a capturing edge, par_err_n is 0 after the next edge. If it was 0, par_err_n is 1.
- R8: An edge that does not capture data (as in R4) leaves par_err_n unchanged at the following edge, whatever par_in was.
- R9: Reset clears the outputs even while gate_en is high and cs_n_in is 2'b11.
- R10: After reset is released, the data outputs stay 0 until the first capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| gate_en | input | 1 | Strap: 1 enables chip-select gating of the data outputs |
| d_in | input | 22 | Address/command data bits |
| cs_n_in | input | 2 | Chip selects, active low |
| cke_in | input | 2 | Clock-enable bits |
| odt_in | input | 2 | Termination-control bits |
| par_in | input | 1 | Parity bit from the controller |
| q_data_a | output | 22 | Registered data, copy A |
| q_data_b | output | 22 | Registered data, copy B |
| q_cs_n_a | output | 2 | Registered chip selects, copy A |
| q_cs_n_b | output | 2 | Registered chip selects, copy B |
| q_cke_a | output | 2 | Registered clock enables, copy A |
| q_cke_b | output | 2 | Registered clock enables, copy B |
| q_odt_a | output | 2 | Registered termination bits, copy A |
| q_odt_b | output | 2 | Registered termination bits, copy B |
| par_err_n | output | 1 | Parity error flag, active low, one clock after the data |

## Verification
The assertions assume that every input holds a known 0 or 1 value at each rising edge and that `rst` is high from time zero. Under that assumption the first edge sets a defined state. The stimulus drives all inputs from the start and changes them only on falling edges. The gate-enable strap changes only between test phases, and `rst` starts high. Parity bits are chosen on purpose to produce both matching and mismatching words, in both captured and gated cycles.

// File: rtl/abuf_pkg.sv
package abuf_pkg;
  localparam int DATA_W_DEF = 22;
  localparam int CS_W_DEF   = 2;
  localparam int CKE_W_DEF  = 2;
  localparam int ODT_W_DEF  = 2;
  localparam int NCOPY      = 2;

  function automatic logic odd_count(input logic [63:0] v, input int w);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < 64; i++)
      if (i < w) acc = acc ^ v[i];
    return acc;
  endfunction
endpackage

// File: rtl/abuf_gate.sv
module abuf_gate #(
  parameter int CS_W = 2
) (
  input  logic            gate_en,
  input  logic [CS_W-1:0] cs_n,
  output logic            capture
);
  // No rank is addressed when every active-low select is high.
  logic idle;
  assign idle    = &cs_n;
  assign capture = !(gate_en && idle);
endmodule

// File: rtl/abuf_lane.sv
module abuf_lane #(
  parameter int DATA_W = 22,
  parameter int CTL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] d,
  input  logic [CTL_W-1:0]  ctl,
  output logic [DATA_W-1:0] q_d,
  output logic [CTL_W-1:0]  q_ctl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_d   <= '0;
      q_ctl <= '0;
    end else begin
      q_ctl <= ctl;
      if (capture) q_d <= d;
    end
  end

  // R1 / R9: reset wins over capture and gating
  a_r1_lane_clear: assert property (@(posedge clk)
    rst |=> (q_d == '0 && q_ctl == '0));
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    capture |=> q_d == $past(d));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(q_d));
  a_r6_ctl_follow: assert property (@(posedge clk) disable iff (rst)
    !capture |=> q_ctl == $past(ctl));
endmodule

// File: rtl/abuf_parity.sv
module abuf_parity #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] d,
  input  logic              par_in,
  output logic              err_n
);
  import abuf_pkg::*;

  localparam int CHK_W = DATA_W + 1;

  logic pend_vld;
  logic pend_bad;
  logic word_odd;

  assign word_odd = odd_count(64'({par_in, d}), CHK_W);

  // Stage 1: parity of the word taken at the capturing edge.
  // Stage 2: flag updated one clock later, only for captured words.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
      pend_bad <= 1'b0;
      err_n    <= 1'b1;
    end else begin
      pend_vld <= capture;
      pend_bad <= word_odd;
      if (pend_vld) err_n <= !pend_bad;
    end
  end

  a_r1_err_idle: assert property (@(posedge clk)
    rst |=> err_n);
  a_r8_err_hold: assert property (@(posedge clk) disable iff (rst)
    !pend_vld |=> $stable(err_n));
  a_r7_err_flag: assert property (@(posedge clk) disable iff (rst)
    capture |=> ##1 (err_n == !$past(word_odd, 2)));
endmodule

// File: rtl/cmd_addr_regbuf.sv
module cmd_addr_regbuf #(
  parameter int DATA_W = abuf_pkg::DATA_W_DEF,
  parameter int CS_W   = abuf_pkg::CS_W_DEF,
  parameter int CKE_W  = abuf_pkg::CKE_W_DEF,
  parameter int ODT_W  = abuf_pkg::ODT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate_en,
  input  logic [DATA_W-1:0] d_in,
  input  logic [CS_W-1:0]   cs_n_in,
  input  logic [CKE_W-1:0]  cke_in,
  input  logic [ODT_W-1:0]  odt_in,
  input  logic              par_in,
  output logic [DATA_W-1:0] q_data_a,
  output logic [DATA_W-1:0] q_data_b,
  output logic [CS_W-1:0]   q_cs_n_a,
  output logic [CS_W-1:0]   q_cs_n_b,
  output logic [CKE_W-1:0]  q_cke_a,
  output logic [CKE_W-1:0]  q_cke_b,
  output logic [ODT_W-1:0]  q_odt_a,
  output logic [ODT_W-1:0]  q_odt_b,
  output logic              par_err_n
);
  import abuf_pkg::*;

  localparam int CTL_W = CS_W + CKE_W + ODT_W;

  logic              capture;
  logic [CTL_W-1:0]  ctl_in;
  logic [DATA_W-1:0] lane_d   [NCOPY];
  logic [CTL_W-1:0]  lane_ctl [NCOPY];

  assign ctl_in = {cs_n_in, cke_in, odt_in};

  abuf_gate #(.CS_W(CS_W)) u_gate (
    .gate_en (gate_en),
    .cs_n    (cs_n_in),
    .capture (capture)
  );

  // One register set per output copy, so that each copy drives its own load.
  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    abuf_lane #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .capture (capture),
      .d       (d_in),
      .ctl     (ctl_in),
      .q_d     (lane_d[c]),
      .q_ctl   (lane_ctl[c])
    );
  end

  abuf_parity #(.DATA_W(DATA_W)) u_par (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .d       (d_in),
    .par_in  (par_in),
    .err_n   (par_err_n)
  );

  assign q_data_a = lane_d[0];
  assign q_data_b = lane_d[1];
  assign {q_cs_n_a, q_cke_a, q_odt_a} = lane_ctl[0];
  assign {q_cs_n_b, q_cke_b, q_odt_b} = lane_ctl[1];

  a_r3_copies_match: assert property (@(posedge clk) disable iff (rst)
    (q_data_a == q_data_b) && (lane_ctl[0] == lane_ctl[1]));
  a_r5_strap_off: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> q_data_a == $past(d_in));
  a_r9_reset_over_gate: assert property (@(posedge clk)
    (rst && gate_en && (&cs_n_in)) |=> (q_data_a == '0 && q_data_b == '0));
  a_r6_ctl_ports: assert property (@(posedge clk) disable iff (rst)
    capture |=> {q_cs_n_b, q_cke_b, q_odt_b} == $past(ctl_in));
endmodule

// File: tb/cmd_addr_regbuf_test.sv
`timescale 1ns/1ps
module cmd_addr_regbuf_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gate_en = 1'b1;
  logic [21:0] d_in = '0;
  logic [1:0]  cs_n_in = 2'b11;
  logic [1:0]  cke_in = '0;
  logic [1:0]  odt_in = '0;
  logic        par_in = 1'b0;
  logic [21:0] q_data_a, q_data_b;
  logic [1:0]  q_cs_n_a, q_cs_n_b, q_cke_a, q_cke_b, q_odt_a, q_odt_b;
  logic        par_err_n;

  always #2 clk = ~clk;

  cmd_addr_regbuf uut (
    .clk(clk), .rst(rst), .gate_en(gate_en), .d_in(d_in),
    .cs_n_in(cs_n_in), .cke_in(cke_in), .odt_in(odt_in), .par_in(par_in),
    .q_data_a(q_data_a), .q_data_b(q_data_b),
    .q_cs_n_a(q_cs_n_a), .q_cs_n_b(q_cs_n_b),
    .q_cke_a(q_cke_a), .q_cke_b(q_cke_b),
    .q_odt_a(q_odt_a), .q_odt_b(q_odt_b),
    .par_err_n(par_err_n)
  );

  typedef struct {
    logic [21:0] data;
    logic [5:0]  ctl;
    logic        err_n;
    string       tag;
  } exp_t;

  exp_t scb[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  // reference model state
  logic [21:0] m_data = '0;
  logic [5:0]  m_ctl  = '0;
  logic        m_vld  = 1'b0;
  logic        m_bad  = 1'b0;
  logic        m_err  = 1'b1;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected result
  task automatic step(input logic r, input logic g, input logic [1:0] cs,
                      input logic [1:0] ke, input logic [1:0] od,
                      input logic [21:0] d, input logic p, input string tag);
    exp_t e;
    logic cap;
    @(negedge clk);
    rst = r; gate_en = g; cs_n_in = cs; cke_in = ke; odt_in = od;
    d_in = d; par_in = p;
    if (r) begin
      m_data = '0; m_ctl = '0; m_vld = 1'b0; m_bad = 1'b0; m_err = 1'b1;
    end else begin
      cap = !(g && cs == 2'b11);
      if (m_vld) m_err = !m_bad;
      m_ctl = {cs, ke, od};
      if (cap) m_data = d;
      m_vld = cap;
      m_bad = ^{p, d};
    end
    e.data = m_data; e.ctl = m_ctl; e.err_n = m_err; e.tag = tag;
    scb.push_back(e);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (scb.size() > 0) begin
      exp_t e;
      e = scb.pop_front();
      chk(e.tag, "q_data_a", 32'(q_data_a), 32'(e.data));
      chk(e.tag, "ctl_a", 32'({q_cs_n_a, q_cke_a, q_odt_a}), 32'(e.ctl));
      chk(e.tag, "par_err_n", 32'(par_err_n), 32'(e.err_n));
      chk("R3", "data_b_vs_a", 32'(q_data_b), 32'(q_data_a));
      chk("R3", "ctl_b_vs_a", 32'({q_cs_n_b, q_cke_b, q_odt_b}),
          32'({q_cs_n_a, q_cke_a, q_odt_a}));
    end
  end

  function automatic logic even_par(input logic [21:0] d);
    return ^d;
  endfunction

  initial begin
    logic [21:0] v;
    // R1 / R9: reset while gated with busy inputs
    step(1, 1, 2'b11, 2'b11, 2'b11, 22'h3FFFFF, 1, "R9");
    step(1, 1, 2'b11, 2'b10, 2'b01, 22'h155555, 0, "R1");
    step(1, 0, 2'b00, 2'b11, 2'b11, 22'h2AAAAA, 1, "R1");
    // R10 / R6: released but gated, data must stay zero, control follows
    step(0, 1, 2'b11, 2'b01, 2'b10, 22'h0ABCDE, 1, "R10");
    step(0, 1, 2'b11, 2'b10, 2'b01, 22'h123456, 0, "R6");
    // R2: capture on each single select
    step(0, 1, 2'b10, 2'b11, 2'b00, 22'h000001, 1, "R2");
    step(0, 1, 2'b01, 2'b00, 2'b11, 22'h200000, 1, "R2");
    step(0, 1, 2'b00, 2'b01, 2'b01, 22'h0F0F0F, even_par(22'h0F0F0F), "R2");
    // R7: good then bad parity
    step(0, 1, 2'b10, 2'b00, 2'b00, 22'h000003, 0, "R7");
    step(0, 1, 2'b10, 2'b00, 2'b00, 22'h000007, 0, "R7");
    step(0, 1, 2'b01, 2'b00, 2'b00, 22'h000007, 1, "R7");
    // R4 / R8: gated with wrong parity, flag and data hold
    step(0, 1, 2'b11, 2'b11, 2'b10, 22'h3C3C3C, 1, "R4");
    step(0, 1, 2'b11, 2'b01, 2'b00, 22'h111111, 1, "R8");
    step(0, 1, 2'b11, 2'b00, 2'b11, 22'h222222, 0, "R8");
    step(0, 1, 2'b00, 2'b00, 2'b11, 22'h000001, 0, "R7");
    step(0, 1, 2'b11, 2'b00, 2'b11, 22'h000000, 1, "R8");
    step(0, 1, 2'b11, 2'b00, 2'b11, 22'h000000, 0, "R8");
    // R5: strap low, updates despite idle selects
    step(0, 0, 2'b11, 2'b10, 2'b10, 22'h2BCDEF, 0, "R5");
    step(0, 0, 2'b11, 2'b01, 2'b01, 22'h012345, 1, "R5");
    step(0, 0, 2'b11, 2'b00, 2'b00, 22'h012345, 0, "R5");
    // mixed random traffic
    for (int i = 0; i < 80; i++) begin
      v = 22'($urandom);
      step(0, i[4], 2'($urandom), 2'($urandom), 2'($urandom), v,
           1'($urandom), "R2");
    end
    // R9: reset mid-run while gated
    step(1, 1, 2'b11, 2'b11, 2'b11, 22'h3FFFFF, 1, "R9");
    step(0, 1, 2'b11, 2'b00, 2'b00, 22'h155555, 1, "R10");
    step(0, 1, 2'b01, 2'b00, 2'b00, 22'h155555, 1, "R2");
    step(0, 1, 2'b11, 2'b00, 2'b00, 22'h000000, 0, "R7");
    step(0, 1, 2'b11, 2'b00, 2'b00, 22'h000000, 0, "R8");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule